// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block is the control state machine that decides how a digital PLL runs. The PLL can run in one of three modes. In free-run it has no reference. In locked it tracks the selected reference. In holdover it keeps its last frequency after it has lost or given up its reference. A 3-bit configuration field chooses between two kinds of control. Either the block's own automatic sequencer picks the mode, or software pins the PLL to one of the three modes.

In automatic operation the sequencer watches two level inputs: whether a reference is selected and whether that reference is qualified. It also takes three single-cycle event strobes, each of which reports that the reference source was changed:
- a higher-priority input was switched in;
- a forced reselection took place;
- the source was redirected to follow another PLL's output.

Any such change takes the PLL out of locked and into holdover, in the same way as a loss of the reference does. The block reports the current mode as a one-hot status word. It raises a one-cycle pulse whenever the mode changes.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is asserted, and until the synchronised release of reset, the status is free-run (001) and the change pulse is low.
- R2: The status output is always one-hot: 001 means free-run, 010 means holdover and 100 means locked.
- R3: In automatic operation, free-run moves to locked one cycle after a reference is both selected and qualified. Otherwise it stays in free-run, and event strobes have no effect there.
- R4: In automatic operation, locked moves to holdover on the next cycle when the reference is no longer qualified or no longer selected.
- R5: In automatic operation, locked moves to holdover on the next cycle when any event strobe is high (bit 0 higher-priority switch, bit 1 forced reselection, bit 2 redirect to another PLL). Several strobes in the same cycle cause a single transition.
- R6: In automatic operation, holdover returns to locked when the reference is selected and qualified. It stays in holdover while the reference is selected but not qualified.
- R7: In automatic operation, holdover falls back to free-run on the next cycle when no reference is selected.
- R8: Configuration codes 001, 010 and 100 force free-run, holdover and locked respectively from the next cycle on, whatever the reference inputs and strobes do.
- R9: Configuration codes 000, 011, 101, 110 and 111 all select automatic operation.
- R10: When the configuration returns to automatic, the sequencer continues from the mode that was being forced.
- R11: The change pulse is high for exactly the one cycle in which the status first shows a new mode. It stays low when the next mode equals the current one, including when a forced mode equals the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 3 | Mode configuration: automatic or one forced mode |
| ref_selected | input | 1 | A reference input is currently selected |
| ref_qualified | input | 1 | The selected reference is qualified |
| evt_switch | input | 3 | Single-cycle reference-change strobes: [0] higher priority, [1] forced reselection, [2] redirect |
| mode_sts | output | 3 | One-hot current operating mode |
| mode_chg | output | 1 | One-cycle pulse on every mode change |

## Verification
The bench covers every exit from locked, each strobe on its own and all three together. A design that let the strobes count separately, or that ignored a reference change while the reference stayed qualified, would show an extra transition or stay stuck in locked. It sets a forced mode equal to the current one and expects no change pulse. A pulse generated from the configuration instead of from the mode would fire there. It returns to automatic from a forced holdover with the reference still unqualified. A design that restarted from free-run would show the wrong status and a spurious pulse. The unused configuration codes are driven while the reference toggles. A decoder that mapped any of them to a forced mode would freeze the status.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  localparam int MODE_W = 3;
  localparam int CFG_W  = 3;
  localparam int EVT_N  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE = 3'b001,
    MODE_HOLD = 3'b010,
    MODE_LOCK = 3'b100
  } mode_e;

  typedef enum logic [CFG_W-1:0] {
    CFG_AUTO  = 3'b000,
    CFG_FFREE = 3'b001,
    CFG_FHOLD = 3'b010,
    CFG_FLOCK = 3'b100
  } cfg_e;

  typedef struct packed {
    logic  force_en;
    mode_e force_mode;
  } cfg_dec_t;

  typedef struct packed {
    logic ref_sel;
    logic ref_ok;
    logic switch_evt;
  } ref_view_t;
endpackage

// File: rtl/dpll_rst_sync.sv
module dpll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpll_cfg_decode.sv
module dpll_cfg_decode
  import dpll_mode_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_mode,
  output cfg_dec_t         cfg_dec
);
  always_comb begin
    cfg_dec.force_en   = 1'b0;
    cfg_dec.force_mode = MODE_FREE;
    case (cfg_mode)
      CFG_FFREE: begin
        cfg_dec.force_en   = 1'b1;
        cfg_dec.force_mode = MODE_FREE;
      end
      CFG_FHOLD: begin
        cfg_dec.force_en   = 1'b1;
        cfg_dec.force_mode = MODE_HOLD;
      end
      CFG_FLOCK: begin
        cfg_dec.force_en   = 1'b1;
        cfg_dec.force_mode = MODE_LOCK;
      end
      default: begin
        cfg_dec.force_en   = 1'b0;
        cfg_dec.force_mode = MODE_FREE;
      end
    endcase
  end
endmodule

// File: rtl/dpll_evt_merge.sv
module dpll_evt_merge
  import dpll_mode_pkg::*;
#(
  parameter int N_EVT = EVT_N
) (
  input  logic [N_EVT-1:0] evt_in,
  input  logic             ref_selected,
  input  logic             ref_qualified,
  output ref_view_t        ref_view
);
  logic [N_EVT-1:0] evt_acc;

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_or
      if (gi == 0) begin : g_first
        assign evt_acc[gi] = evt_in[gi];
      end else begin : g_rest
        assign evt_acc[gi] = evt_acc[gi-1] | evt_in[gi];
      end
    end
  endgenerate

  assign ref_view.ref_sel    = ref_selected;
  assign ref_view.ref_ok     = ref_qualified;
  assign ref_view.switch_evt = evt_acc[N_EVT-1];
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cfg_dec_t    cfg_dec,
  input  ref_view_t   ref_view,
  output mode_e       mode_q,
  output logic        chg_q
);
  mode_e mode_d;
  logic  chg_d;
  logic  ref_good;
  logic  lock_exit;

  assign ref_good  = ref_view.ref_sel & ref_view.ref_ok;
  assign lock_exit = ~ref_good | ref_view.switch_evt;

  always_comb begin
    mode_d = mode_q;
    if (cfg_dec.force_en) begin
      mode_d = cfg_dec.force_mode;
    end else begin
      case (mode_q)
        MODE_FREE: if (ref_good) mode_d = MODE_LOCK;
        MODE_LOCK: if (lock_exit) mode_d = MODE_HOLD;
        MODE_HOLD: begin
          if (!ref_view.ref_sel) mode_d = MODE_FREE;
          else if (ref_view.ref_ok) mode_d = MODE_LOCK;
        end
        default: mode_d = MODE_FREE;
      endcase
    end
    chg_d = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= chg_d;
    end
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_mode,
  input  logic              ref_selected,
  input  logic              ref_qualified,
  input  logic [EVT_N-1:0]  evt_switch,
  output logic [MODE_W-1:0] mode_sts,
  output logic              mode_chg
);
  logic      core_rst_n;
  cfg_dec_t  cfg_dec;
  ref_view_t ref_view;
  mode_e     mode_q;

  dpll_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  dpll_cfg_decode u_cfg (
    .cfg_mode (cfg_mode),
    .cfg_dec  (cfg_dec)
  );

  dpll_evt_merge #(.N_EVT(EVT_N)) u_evt (
    .evt_in        (evt_switch),
    .ref_selected  (ref_selected),
    .ref_qualified (ref_qualified),
    .ref_view      (ref_view)
  );

  dpll_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cfg_dec  (cfg_dec),
    .ref_view (ref_view),
    .mode_q   (mode_q),
    .chg_q    (mode_chg)
  );

  assign mode_sts = mode_q;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_mode,
  input logic       ref_selected,
  input logic       ref_qualified,
  input logic [2:0] evt_switch,
  input logic [2:0] mode_sts,
  input logic       mode_chg
);
  logic auto_c;
  assign auto_c = (cfg_mode != 3'b001) && (cfg_mode != 3'b010) && (cfg_mode != 3'b100);

  AST_STS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_sts) == 1); // R2
  AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg == (mode_sts != $past(mode_sts))); // R11
  AST_FORCE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b100) |=> (mode_sts == 3'b100)); // R8
  AST_FORCE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'b001) |=> (mode_sts == 3'b001)); // R8
  AST_LOCK_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_c && mode_sts == 3'b100 && evt_switch != 3'b000) |=> (mode_sts == 3'b010)); // R5
  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_c && mode_sts == 3'b100 && !(ref_selected && ref_qualified)) |=> (mode_sts == 3'b010)); // R4
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_c && mode_sts == 3'b010 && !ref_selected) |=> (mode_sts == 3'b001)); // R7
  AST_FREE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_c && mode_sts == 3'b001) |=> (mode_sts != 3'b010)); // R3
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (core_rst_n),
  .cfg_mode      (cfg_mode),
  .ref_selected  (ref_selected),
  .ref_qualified (ref_qualified),
  .evt_switch    (evt_switch),
  .mode_sts      (mode_sts),
  .mode_chg      (mode_chg)
);

// File: tb/dpll_mode_ctrl_bench.sv
module dpll_mode_ctrl_bench;
  localparam logic [2:0] FR = 3'b001;
  localparam logic [2:0] HO = 3'b010;
  localparam logic [2:0] LK = 3'b100;

  logic       clk;
  logic       rst_n;
  logic [2:0] cfg_mode;
  logic       ref_selected;
  logic       ref_qualified;
  logic [2:0] evt_switch;
  logic [2:0] mode_sts;
  logic       mode_chg;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] mode;
    logic       chg;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  dpll_mode_ctrl u_dpll_mode_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .ref_selected  (ref_selected),
    .ref_qualified (ref_qualified),
    .evt_switch    (evt_switch),
    .mode_sts      (mode_sts),
    .mode_chg      (mode_chg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual mode/chg=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the result expected after the next edge
  task automatic step(input logic [2:0] cfg, input logic sel, input logic qual,
                      input logic [2:0] evt, input logic [2:0] em, input logic ec,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cfg_mode      = cfg;
    ref_selected  = sel;
    ref_qualified = qual;
    evt_switch    = evt;
    e.mode = em;
    e.chg  = ec;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // monitor: one time unit after each edge, compare against the oldest expectation
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, {mode_sts, mode_chg}, {e.mode, e.chg});
      check("R2 onehot", {3'b000, ($countones(mode_sts) == 1)}, 4'b0001);
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_mode = 3'b000;
    ref_selected = 1'b1;
    ref_qualified = 1'b1;
    evt_switch = 3'b000;
    repeat (3) @(negedge clk);
    check("R1 reset", {mode_sts, mode_chg}, {FR, 1'b0});
    rst_n = 1'b1;
    ref_selected = 1'b0;
    ref_qualified = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 after release", {mode_sts, mode_chg}, {FR, 1'b0});

    step(3'b000, 0, 0, 3'b000, FR, 0, "R3 idle");
    step(3'b000, 1, 0, 3'b000, FR, 0, "R3 unqualified");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R3 lock");
    step(3'b000, 1, 1, 3'b000, LK, 0, "R11 steady");
    step(3'b000, 1, 0, 3'b000, HO, 1, "R4 disqualify");
    step(3'b000, 1, 0, 3'b000, HO, 0, "R6 stay hold");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R6 relock");
    step(3'b000, 1, 1, 3'b001, HO, 1, "R5 higher prio");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R6 relock");
    step(3'b000, 1, 1, 3'b010, HO, 1, "R5 forced sel");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R6 relock");
    step(3'b000, 1, 1, 3'b100, HO, 1, "R5 redirect");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R6 relock");
    step(3'b000, 1, 1, 3'b111, HO, 1, "R5 all strobes");
    step(3'b000, 0, 0, 3'b000, FR, 1, "R7 drop");
    step(3'b000, 0, 0, 3'b111, FR, 0, "R3 strobe ignored in free");
    step(3'b000, 1, 1, 3'b000, LK, 1, "R3 lock");
    step(3'b000, 0, 1, 3'b000, HO, 1, "R4 deselect");
    step(3'b000, 0, 0, 3'b000, FR, 1, "R7 drop");

    step(3'b100, 0, 0, 3'b000, LK, 1, "R8 force lock");
    step(3'b100, 1, 0, 3'b111, LK, 0, "R8 lock held");
    step(3'b010, 1, 1, 3'b000, HO, 1, "R8 force hold");
    step(3'b001, 1, 1, 3'b000, FR, 1, "R8 force free");
    step(3'b001, 1, 1, 3'b000, FR, 0, "R11 forced same");
    step(3'b010, 1, 0, 3'b000, HO, 1, "R8 force hold");
    step(3'b000, 1, 0, 3'b000, HO, 0, "R10 resume hold");
    step(3'b100, 1, 1, 3'b000, LK, 1, "R8 force lock");
    step(3'b000, 1, 1, 3'b000, LK, 0, "R10 resume lock");

    step(3'b011, 1, 0, 3'b000, HO, 1, "R9 code 011");
    step(3'b111, 1, 1, 3'b000, LK, 1, "R9 code 111");
    step(3'b101, 1, 1, 3'b100, HO, 1, "R9 code 101");
    step(3'b110, 0, 0, 3'b000, FR, 1, "R9 code 110");

    @(negedge clk);
    cfg_mode = 3'b000;
    evt_switch = 3'b000;
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule